// File: doc/BRIEF.md
# Half to single float converter

This block widens a 16-bit IEEE binary16 operand into the 32-bit IEEE binary32 value that represents the same number. Every half-precision code has an exact single-precision image, so no rounding takes place: signed zeros stay signed zeros, infinities stay infinities, subnormal halves become normal singles, and NaNs become quiet NaNs that keep their payload bits.

The block is a two-stage stream with no backpressure. An operand enters with `in_valid`. Two clock edges later the converted word appears with `out_valid`. Operands may be presented on every cycle or with idle gaps of any length. The first stage classifies the operand. For subnormals it finds the leading one with a single-cycle priority encoder and shifts it out. It also computes the output exponent and fraction, and registers them. The second stage assembles the 32-bit word and registers it.

Top module: `half_to_single_widen`

## Requirements
- R1: Bit 31 of `out_single` equals bit 15 of the operand that produced it, for every input code.
- R2: `out_valid` is high exactly two clock edges after `in_valid` was sampled high, and is low in all other cycles. It is low while `rst_n` is low. Back-to-back operands give back-to-back results in the same order.
- R3: An operand with exponent field (bits 14:10) equal to 31 and fraction (bits 9:0) equal to zero gives exponent field 0xFF (bits 30:23) and fraction field zero (bits 22:0), which is infinity.
- R4: An operand with exponent field 31 and a nonzero fraction gives exponent field 0xFF and output bit 22 set to one. Output bits 21:13 equal operand bits 8:0, and output bits 12:0 are zero.
- R5: An operand with bits 14:0 all zero gives output bits 30:0 all zero, which is a signed zero.
- R6: An operand with exponent field 0 and a nonzero fraction, whose highest set fraction bit is at position p (0..9), gives exponent field 103+p. The output fraction field holds the operand fraction bits below p, left-aligned at bit 22, and zeros below them.
- R7: An operand with exponent field e in 1..30 gives exponent field e+112. Output bits 22:13 equal operand bits 9:0, and output bits 12:0 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand qualifier |
| in_half | input | 16 | binary16 operand |
| out_valid | output | 1 | Result qualifier, two cycles after `in_valid` |
| out_single | output | 32 | binary32 result |

## Verification
The hardest cases to reach are the subnormal renormalisation paths. Each leading-one position uses a different shift amount and a different exponent, and the position-9 and position-0 extremes sit at opposite ends of the encoder. The stimulus streams every one of the 65536 codes through the block back to back, so every shift distance and every NaN payload is seen, along with both signs of zero and infinity. The expected word comes from a bench function that rebuilds each value by arithmetic. A second pass sends a subset of codes with irregular idle gaps, which tests that the valid timing tracks the data.

// File: rtl/hsw_pkg.sv
package hsw_pkg;

    localparam int HALF_EXP_W    = 5;
    localparam int HALF_FRAC_W   = 10;
    localparam int HALF_W        = 1 + HALF_EXP_W + HALF_FRAC_W;
    localparam int SGL_EXP_W     = 8;
    localparam int SGL_FRAC_W    = 23;
    localparam int SGL_W         = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int HALF_BIAS     = (1 << (HALF_EXP_W - 1)) - 1;
    localparam int SGL_BIAS      = (1 << (SGL_EXP_W - 1)) - 1;
    localparam int BIAS_DELTA    = SGL_BIAS - HALF_BIAS;
    localparam int FRAC_SHIFT    = SGL_FRAC_W - HALF_FRAC_W;
    localparam int POS_W         = $clog2(HALF_FRAC_W);
    // exponent of a subnormal whose leading one sits at position 0
    localparam int SUB_EXP_BASE  = BIAS_DELTA + 1 - HALF_FRAC_W;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } fp_class_e;

    typedef struct packed {
        logic                   vld;
        logic                   sign;
        fp_class_e              cls;
        logic [SGL_EXP_W-1:0]   exp;
        logic [HALF_FRAC_W-1:0] frac;
    } stage_t;

endpackage

// File: rtl/hsw_lead_one.sv
module hsw_lead_one #(
    parameter int W     = 10,
    parameter int POS_W = $clog2(W)
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [POS_W-1:0] pos
);

    // priority encoder: highest set bit wins
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                found = 1'b1;
                pos   = POS_W'(i);
            end
        end
    end

    always_comb begin
        if (found) begin
            a_r6_leading_one_top: assert ((vec >> pos) == W'(1))
                else $error("leading-one position does not mark the top bit");
        end
    end

endmodule

// File: rtl/hsw_unpack.sv
module hsw_unpack
    import hsw_pkg::*;
(
    input  logic              vld,
    input  logic [HALF_W-1:0] half,
    output stage_t            dec
);

    logic [HALF_EXP_W-1:0]  exp_f;
    logic [HALF_FRAC_W-1:0] frac_f;
    logic                   exp_max;
    logic                   exp_min;
    logic                   lo_found;
    logic [POS_W-1:0]       lo_pos;
    logic [POS_W-1:0]       sh_amt;
    logic [HALF_FRAC_W:0]   aligned;

    assign exp_f   = half[HALF_W-2 -: HALF_EXP_W];
    assign frac_f  = half[HALF_FRAC_W-1:0];
    assign exp_max = &exp_f;
    assign exp_min = ~|exp_f;

    hsw_lead_one #(
        .W     (HALF_FRAC_W),
        .POS_W (POS_W)
    ) u_lead (
        .vec   (frac_f),
        .found (lo_found),
        .pos   (lo_pos)
    );

    // move the leading one up to the hidden-bit position
    assign sh_amt  = POS_W'(HALF_FRAC_W) - lo_pos;
    assign aligned = {1'b0, frac_f} << sh_amt;

    always_comb begin
        dec      = '0;
        dec.vld  = vld;
        dec.sign = half[HALF_W-1];
        if (exp_max) begin
            dec.cls  = lo_found ? CLS_NAN : CLS_INF;
            dec.exp  = '1;
            dec.frac = frac_f;
        end else if (exp_min) begin
            if (!lo_found) begin
                dec.cls  = CLS_ZERO;
                dec.exp  = '0;
                dec.frac = '0;
            end else begin
                dec.cls  = CLS_SUB;
                dec.exp  = SGL_EXP_W'(SUB_EXP_BASE) + SGL_EXP_W'(lo_pos);
                dec.frac = aligned[HALF_FRAC_W-1:0];
            end
        end else begin
            dec.cls  = CLS_NORM;
            dec.exp  = SGL_EXP_W'(exp_f) + SGL_EXP_W'(BIAS_DELTA);
            dec.frac = frac_f;
        end
    end

    always_comb begin
        if (exp_min && lo_found) begin
            a_r6_hidden_bit_set: assert (aligned[HALF_FRAC_W])
                else $error("normalisation shift missed the hidden bit");
        end
    end

endmodule

// File: rtl/hsw_assemble.sv
module hsw_assemble
    import hsw_pkg::*;
(
    input  stage_t             st,
    output logic [SGL_W-1:0]   word
);

    localparam logic [FRAC_SHIFT-1:0] PAD = '0;

    always_comb begin
        unique case (st.cls)
            CLS_ZERO: word = {st.sign, {(SGL_W-1){1'b0}}};
            CLS_INF:  word = {st.sign, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
            CLS_NAN:  word = {st.sign, {SGL_EXP_W{1'b1}}, 1'b1,
                              st.frac[HALF_FRAC_W-2:0], PAD};
            default:  word = {st.sign, st.exp, st.frac, PAD};
        endcase
    end

endmodule

// File: rtl/half_to_single_widen.sv
module half_to_single_widen
    import hsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_half,
    output logic              out_valid,
    output logic [31:0]       out_single
);

    typedef struct packed {
        stage_t            s1;
        logic              ovld;
        logic [SGL_W-1:0]  odata;
    } pipe_t;

    pipe_t             pipe_d;
    pipe_t             pipe_q;
    stage_t            dec;
    logic [SGL_W-1:0]  packed_word;

    hsw_unpack u_unpack (
        .vld  (in_valid),
        .half (in_half),
        .dec  (dec)
    );

    hsw_assemble u_assemble (
        .st   (pipe_q.s1),
        .word (packed_word)
    );

    always_comb begin
        pipe_d       = pipe_q;
        pipe_d.s1    = dec;
        pipe_d.ovld  = pipe_q.s1.vld;
        pipe_d.odata = packed_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.ovld;
    assign out_single = pipe_q.odata;

    a_r1_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_single[31] == $past(in_half[15], 2))
        else $error("sign bit not carried");

    a_r2_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> pipe_q.s1.vld)
        else $error("operand not captured");

    a_r2_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.s1.vld |=> out_valid)
        else $error("result not issued");

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_q.s1.vld |=> !out_valid)
        else $error("result without operand");

    a_r4_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_single[30:23]) && (|out_single[22:0]))
            |-> out_single[22])
        else $error("NaN result not quiet");

    a_r5_zero_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_half[14:0], 2) == 15'd0)
            |-> out_single[30:0] == 31'd0)
        else $error("zero not preserved");

    a_r7_low_bits_clear: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_single[12:0] == 13'd0)
        else $error("low fraction bits not zero");

endmodule

// File: tb/sim_half_to_single_widen.sv
module sim_half_to_single_widen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_half = '0;
    logic        out_valid;
    logic [31:0] out_single;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // bench view of the two-cycle latency from R2
    logic        h0_v = 1'b0, h1_v = 1'b0;
    logic [15:0] h0_c = '0,   h1_c = '0;

    always #4 clk = ~clk;

    half_to_single_widen u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_half    (in_half),
        .out_valid  (out_valid),
        .out_single (out_single)
    );

    function automatic logic [31:0] ref_conv(input logic [15:0] h);
        int e = int'(h[14:10]);
        int m = int'(h[9:0]);
        longint r = 0;
        int p = 0;
        if (h[15]) r = 64'h8000_0000;
        if (e == 31) begin
            r += 64'h7F80_0000;
            if (m != 0) r = r | 64'h0040_0000 | (longint'(m) << 13);
        end else if (e == 0) begin
            if (m != 0) begin
                for (int k = 0; k < 10; k++) if (((m >> k) & 1) == 1) p = k;
                r += longint'(p - 24 + 127) << 23;
                r += longint'(m - (1 << p)) << (23 - p);
            end
        end else begin
            r += longint'(e - 15 + 127) << 23;
            r += longint'(m) << 13;
        end
        return r[31:0];
    endfunction

    function automatic string req_of(input logic [15:0] h);
        if (h[14:10] == 5'd31) return (h[9:0] == 0) ? "R3" : "R4";
        if (h[14:10] == 5'd0)  return (h[9:0] == 0) ? "R5" : "R6";
        return "R7";
    endfunction

    task automatic check_out();
        checks++;
        if (out_valid !== h1_v) begin
            errors++;
            $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, h1_v);
        end
        if (h1_v) begin
            logic [31:0] exp_w = ref_conv(h1_c);
            checks++;
            if (out_single !== exp_w) begin
                errors++;
                $display("FAIL %s/R1 code %h actual %h expected %h",
                         req_of(h1_c), h1_c, out_single, exp_w);
            end
        end
    endtask

    // drive at the falling edge, after checking what the last rising edges produced
    task automatic step(input logic v, input logic [15:0] c);
        @(negedge clk);
        check_out();
        h1_v = h0_v; h1_c = h0_c;
        h0_v = v;    h0_c = c;
        in_valid = v;
        in_half  = c;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        // reset state, R2
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R2 reset out_valid actual %0b expected 0", out_valid);
        end
        rst_n = 1'b1;
        // spot corners named by R1, R3..R7
        step(1'b1, 16'h0000);  // R5 +0
        step(1'b1, 16'h8000);  // R5 -0
        step(1'b1, 16'h7C00);  // R3
        step(1'b1, 16'hFC00);  // R3 negative
        step(1'b1, 16'h7C01);  // R4 payload bit 0
        step(1'b1, 16'h7E00);  // R4 already quiet
        step(1'b1, 16'h0001);  // R6 p=0
        step(1'b1, 16'h0200);  // R6 p=9
        step(1'b1, 16'h83FF);  // R6 negative
        step(1'b1, 16'h0400);  // R7 smallest normal
        step(1'b1, 16'h7BFF);  // R7 largest normal
        // exhaustive sweep, back to back
        for (int i = 0; i < 65536; i++) step(1'b1, 16'(i));
        // irregular gaps, R2
        for (int i = 0; i < 300; i++) begin
            step(1'b1, 16'(i * 217));
            for (int g = 0; g < (i % 4); g++) step(1'b0, 16'hFFFF);
        end
        step(1'b0, '0);
        step(1'b0, '0);
        step(1'b0, '0);
        finish_run();
    end

endmodule